// File: doc/BRIEF.md
# I2C Master Bus Command Engine

This block is the bus-facing engine of a register-driven I2C controller. Software steers it through a small register file. It can raise a START condition, a repeated START condition or a STOP condition on the bus. It can also send one byte and then collect the target's acknowledge bit. Each bus action runs in quarter-bit steps, and the length of a step is set by a programmable timing word. The engine drives both bus lines as open-drain outputs: a 1 on an output-enable pulls the line low. A pad gate can release both lines, whatever the engine is doing.

A bus command is issued by writing the control word. Bit 0 is the enable. Bits 2:1 hold the command code: 0 means no action, 1 means START or restart, 2 means STOP. Bit 3 selects between a fresh START and a repeated START. When a byte is written to the data register, it is shifted out onto the bus. Every finished action sets a sticky flag that software clears. After each bus command completes, software writes the no-action code before it issues the next request. An interrupt line reports any status flag whose enable bit is set.

Register map (3-bit address): 0 control, 1 transmit data, 2 status, 3 interrupt enable, 4 timing, 5 pad control.

Top module: `i2cm_top`

## Requirements
- R1: After reset: control reads 0x00, status reads 0x00 and pad control reads 0x04. Both line outputs are released and the interrupt is low.
- R2: Control write with enable=1, command=1 and bit 3=0, outside a session, produces a START. SDA falls while SCL is high, then SCL is pulled low. The action takes exactly 4 quarter steps. Busy (status bit 7) drops and session done (status bit 3) sets on the same edge, and a session opens.
- R3: A byte written to the data register goes out MSB first on 8 SCL high pulses, followed by a ninth pulse in which SDA is released for the acknowledge. During a byte, SDA changes only while SCL is low.
- R4: After a byte, control bit 3 reads 1 if SDA was high in the acknowledge slot and 0 if it was low. Status bit 0 sets on a missing acknowledge. Status bit 1 (transmit empty) sets when the byte is done.
- R5: With command=1 and bit 3=1 inside a session, the engine makes a repeated START: it releases SDA, then SCL, then pulls SDA low while SCL is high.
- R6: Command=2 inside a session makes a STOP: SDA rises while SCL is high. The session then ends.
- R7: The following requests set the error flag (status bit 2) and cause no bus activity: a START inside a session; a repeated START, STOP or data byte outside a session; command code 3; any request while busy; any request with enable=0; any request made before the no-action code has been written after the previous command.
- R8: Writing status clears exactly those flags whose written bits are 1.
- R9: The interrupt output is high exactly when some status bit and its matching interrupt-enable bit are both 1.
- R10: Pad control bit 2 = 1 keeps both line outputs released, even while a command runs.
- R11: One quarter step lasts (pre+1)·(p+1)·(nodiv ? 1 : div+1) clock cycles, where the timing word is pre[7:6], p[5:3], nodiv[2] and div[1:0]. A byte takes 36 quarter steps from the write edge until busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data of the addressed register (combinational) |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that register writes arrive on clean single-cycle strobes. They also assume that SDA seen at the input is the open-drain AND of the engine's own drive and a target that pulls the line only during the acknowledge slot. The bench models such a target. It counts SCL falling edges from each data write and pulls SDA only between the eighth and ninth falling edges. A bus monitor flags any SDA edge while SCL is high as a START or a STOP, so no stray condition can go unseen. Random bytes, acknowledge choices and timing words are drawn from a fixed seed, and directed writes cover each illegal request.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int BIT_CNT_W = $clog2(DATA_W + 1);
  localparam int QLEN_W    = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TIM  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PAD  = 3'd5;

  typedef enum logic [1:0] {OP_START = 2'd0, OP_STOP = 2'd1, OP_BYTE = 2'd2} busOp_e;

  typedef struct packed {
    logic              go;
    busOp_e            op;
    logic [DATA_W-1:0] txByte;
  } dpCmd_t;
endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [7:0]        timing,
  input  logic              sdaIn,
  output logic              sclLow,
  output logic              sdaLow,
  output logic              active,
  output logic              done,
  output logic              ackBit,
  output busOp_e            op
);
  logic [QLEN_W-1:0]    qLen, cnt;
  logic [DATA_W-1:0]    shreg;
  logic [1:0]           ph;
  logic [BIT_CNT_W-1:0] bitIdx;
  logic                 tick, lastStep;

  // quarter-step length from the packed timing word
  always_comb begin
    qLen = QLEN_W'((QLEN_W'(timing[7:6]) + 1'b1) * (QLEN_W'(timing[5:3]) + 1'b1)
                   * (timing[2] ? QLEN_W'(1) : QLEN_W'(timing[1:0]) + 1'b1));
  end

  assign tick     = active && (cnt == qLen - 1'b1);
  assign lastStep = (ph == 2'd3) && (op != OP_BYTE || bitIdx == BIT_CNT_W'(DATA_W));
  assign done     = tick && lastStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLow <= 1'b0;
      sdaLow <= 1'b0;
      active <= 1'b0;
      ackBit <= 1'b0;
      op     <= OP_START;
      ph     <= '0;
      bitIdx <= '0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (cmd.go) begin
      active <= 1'b1;
      op     <= cmd.op;
      ph     <= '0;
      bitIdx <= '0;
      cnt    <= '0;
      shreg  <= cmd.txByte;
      unique case (cmd.op)
        OP_START: sdaLow <= 1'b0;
        OP_STOP:  sdaLow <= 1'b1;
        OP_BYTE:  sdaLow <= ~cmd.txByte[DATA_W-1];
        default:  ;
      endcase
    end else if (tick) begin
      cnt <= '0;
      if (ph == 2'd2 && op == OP_BYTE && bitIdx == BIT_CNT_W'(DATA_W))
        ackBit <= sdaIn;
      if (lastStep) begin
        active <= 1'b0;
      end else begin
        ph <= ph + 1'b1;
        unique case (op)
          OP_START: begin
            if (ph == 2'd0) sclLow <= 1'b0;
            if (ph == 2'd1) sdaLow <= 1'b1;
            if (ph == 2'd2) sclLow <= 1'b1;
          end
          OP_STOP: begin
            if (ph == 2'd0) sclLow <= 1'b0;
            if (ph == 2'd1) sdaLow <= 1'b0;
          end
          OP_BYTE: begin
            if (ph == 2'd0) sclLow <= 1'b0;
            if (ph == 2'd2) sclLow <= 1'b1;
            if (ph == 2'd3) begin
              bitIdx <= bitIdx + 1'b1;
              shreg  <= {shreg[DATA_W-2:0], 1'b0};
              sdaLow <= (bitIdx == BIT_CNT_W'(DATA_W - 1)) ? 1'b0 : ~shreg[DATA_W-2];
            end
          end
          default: ;
        endcase
      end
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              dpActive,
  input  logic              dpDone,
  input  logic              dpAckBit,
  input  busOp_e            dpOp,
  output dpCmd_t            dpCmd,
  output logic [7:0]        timing,
  output logic              padDis,
  output logic [7:0]        statusVec,
  output logic              irq
);
  logic       en, session, ackRes;
  logic [1:0] cmdField;
  logic       stNack, stTx, stErr, stDone;
  logic [7:0] ien;
  logic       wrCtrl, wrByte, wrStat, cmdReq, cmdLegal, canIssue;
  logic       goCmd, goData, errReq;

  assign wrCtrl   = wrEn && regAddr == A_CTRL;
  assign wrByte   = wrEn && regAddr == A_DATA;
  assign wrStat   = wrEn && regAddr == A_STAT;
  assign cmdReq   = wrCtrl && wrData[2:1] != 2'd0;
  assign canIssue = !dpActive && cmdField == 2'd0;

  always_comb begin
    unique case (wrData[2:1])
      2'd1:    cmdLegal = wrData[3] ? session : !session;
      2'd2:    cmdLegal = session;
      default: cmdLegal = 1'b0;
    endcase
  end

  assign goCmd  = cmdReq && wrData[0] && canIssue && cmdLegal;
  assign goData = wrByte && en && canIssue && session;
  assign errReq = (cmdReq && !goCmd) || (wrByte && !goData);

  assign dpCmd.go     = goCmd || goData;
  assign dpCmd.op     = goData ? OP_BYTE : (wrData[2:1] == 2'd2 ? OP_STOP : OP_START);
  assign dpCmd.txByte = wrData;

  assign statusVec = {dpActive, 3'b000, stDone, stErr, stTx, stNack};
  assign irq       = |(statusVec & ien);

  always_comb begin
    unique case (regAddr)
      A_CTRL:  rdData = {4'b0000, ackRes, cmdField, en};
      A_STAT:  rdData = statusVec;
      A_IEN:   rdData = ien;
      A_TIM:   rdData = timing;
      A_PAD:   rdData = {5'b00000, padDis, 2'b00};
      default: rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en       <= 1'b0;
      cmdField <= 2'd0;
      session  <= 1'b0;
      ackRes   <= 1'b0;
      stNack   <= 1'b0;
      stTx     <= 1'b0;
      stErr    <= 1'b0;
      stDone   <= 1'b0;
      ien      <= '0;
      timing   <= '0;
      padDis   <= 1'b1;
    end else begin
      if (wrCtrl) begin
        en <= wrData[0];
        if (goCmd || wrData[2:1] == 2'd0) cmdField <= wrData[2:1];
      end
      if (goCmd) session <= (wrData[2:1] == 2'd1);
      if (wrEn && regAddr == A_IEN) ien    <= wrData;
      if (wrEn && regAddr == A_TIM) timing <= wrData;
      if (wrEn && regAddr == A_PAD) padDis <= wrData[2];
      // write-one-to-clear first, new events after so that they win
      if (wrStat) begin
        stNack <= stNack & ~wrData[0];
        stTx   <= stTx   & ~wrData[1];
        stErr  <= stErr  & ~wrData[2];
        stDone <= stDone & ~wrData[3];
      end
      if (errReq) stErr <= 1'b1;
      if (dpDone) begin
        stDone <= 1'b1;
        if (dpOp == OP_BYTE) begin
          stTx   <= 1'b1;
          ackRes <= dpAckBit;
          if (dpAckBit) stNack <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              irq
);
  dpCmd_t     dpCmd;
  logic [7:0] timing, statusVec;
  logic       padDis, sclLow, sdaLow, dpActive, dpDone, dpAckBit;
  busOp_e     dpOp;

  i2cm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .dpActive(dpActive), .dpDone(dpDone), .dpAckBit(dpAckBit),
    .dpOp(dpOp), .dpCmd(dpCmd), .timing(timing), .padDis(padDis),
    .statusVec(statusVec), .irq(irq)
  );

  i2cm_datapath i_dp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .timing(timing), .sdaIn(sdaIn),
    .sclLow(sclLow), .sdaLow(sdaLow), .active(dpActive), .done(dpDone),
    .ackBit(dpAckBit), .op(dpOp)
  );

  assign sclOe = !padDis && sclLow;
  assign sdaOe = !padDis && sdaLow;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] regAddr,
  input logic       padBit,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       busy,
  input logic       sclLow,
  input logic       sdaLow,
  input logic       opByte,
  input logic       stDone,
  input logic       stTx
);
  // R3: inside a byte, SDA moves only with SCL held low
  p_sda_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opByte && !$stable(sdaLow)) |-> (sclLow && $past(sclLow)));

  // R7: the engine starts only in response to a register write
  p_start_on_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn));

  // R2: completion of any action sets session done
  p_done_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> stDone);

  // R4: completion of a byte sets transmit empty
  p_tx_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && opByte) |-> stTx);

  // R10: disabling the pads releases both lines
  p_pad_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && regAddr == 3'd5 && padBit) |-> (!sclOe && !sdaOe));
endmodule

bind i2cm_top i2cm_chk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .padBit(wrData[2]),
  .sclOe(sclOe), .sdaOe(sdaOe), .busy(dpActive), .sclLow(sclLow), .sdaLow(sdaLow),
  .opByte(dpOp == i2cm_pkg::OP_BYTE), .stDone(statusVec[3]), .stTx(statusVec[1])
);

// File: tb/test_i2cm_top.sv
`timescale 1ns/1ps
module test_i2cm_top;
  localparam logic [2:0] CTRL = 3'd0, DATA = 3'd1, STAT = 3'd2, IEN = 3'd3, TIM = 3'd4, PAD = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn;
  logic [2:0] regAddr;
  logic [7:0] wrData, rdData;
  logic sclOe, sdaOe, irq, sdaIn;
  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // open-drain bus with a target that may acknowledge
  logic tgtAck = 1'b0, byteOn = 1'b0, padWatch = 1'b0;
  int fallTotal = 0, fallBase = 0, riseTotal = 0, startCnt = 0, stopCnt = 0, padViol = 0;
  logic [8:0] capSh = '0;
  wire sclW = ~sclOe;
  wire tgtPull = byteOn && tgtAck && (fallTotal - fallBase == 8);
  wire sdaW = ~(sdaOe | tgtPull);
  assign sdaIn = sdaW;

  always @(negedge sclW) fallTotal++;
  always @(posedge sclW) begin capSh = {capSh[7:0], sdaW}; riseTotal++; end
  always @(negedge sdaW) if (sclW === 1'b1 && rstN) startCnt++;
  always @(posedge sdaW) if (sclW === 1'b1 && rstN) stopCnt++;
  always @(posedge clk) if (padWatch && (sclOe || sdaOe)) padViol++;

  i2cm_top i_i2cm_top (.clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq));

  function automatic int qlen(input logic [7:0] t);
    return (int'(t[7:6]) + 1) * (int'(t[5:3]) + 1) * (t[2] ? 1 : int'(t[1:0]) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = rdData;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    regAddr = a; #1 d = rdData;
  endtask

  task automatic waitDone();
    logic [7:0] s;
    for (int k = 0; k < 20000; k++) begin
      regRd(STAT, s);
      if (s[3] && !s[7]) break;
    end
  endtask

  task automatic expectErr(input logic [2:0] a, input logic [7:0] d, input string req);
    logic [7:0] s;
    int s0, p0;
    s0 = startCnt; p0 = stopCnt;
    regWr(a, d);
    repeat (3) @(negedge clk);
    regRd(STAT, s);
    chk(s[2] && !s[7] && startCnt == s0 && stopCnt == p0, req, s, 8'h04);
    regWr(STAT, 8'h0F);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic ack, input bit timed, input int qL);
    logic [7:0] s, c;
    int s0, p0, r0;
    s0 = startCnt; p0 = stopCnt; r0 = riseTotal;
    tgtAck = ack; fallBase = fallTotal; byteOn = 1'b1;
    regWr(DATA, b);
    if (timed) begin
      repeat (36 * qL - 1) @(negedge clk);
      peek(STAT, s);
      chk(s[7] && !s[3], "R11 byte still busy", s, 8'h80);
      @(negedge clk);
      peek(STAT, s);
      chk(!s[7] && s[3], "R11 byte done on time", s, 8'h08);
    end else waitDone();
    byteOn = 1'b0;
    chk(capSh[8:1] == b && riseTotal - r0 == 9, "R3 byte on bus", capSh[8:1], b);
    chk(startCnt == s0 && stopCnt == p0, "R3 no stray condition", startCnt - s0 + stopCnt - p0, 0);
    regRd(CTRL, c);
    chk(c[3] == !ack, "R4 ack readback", c[3], !ack);
    regRd(STAT, s);
    chk(s[0] == !ack && s[1], "R4 status flags", s[1:0], {1'b1, !ack});
  endtask

  initial begin
    logic [7:0] v, tm;
    int L, s0, seedDummy;
    seedDummy = $urandom(32'h5eed);
    wrEn = 1'b0; regAddr = '0; wrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    regRd(CTRL, v); chk(v == 8'h00, "R1 control", v, 0);
    regRd(STAT, v); chk(v == 8'h00, "R1 status", v, 0);
    regRd(PAD, v);  chk(v == 8'h04, "R1 pad", v, 4);
    chk(!sclOe && !sdaOe && !irq, "R1 outputs", {sclOe, sdaOe, irq}, 0);

    regWr(PAD, 8'h00);
    // R7: illegal requests outside a session
    expectErr(CTRL, 8'h0B, "R7 restart outside session");
    expectErr(CTRL, 8'h05, "R7 stop outside session");
    expectErr(CTRL, 8'h07, "R7 command code 3");
    expectErr(CTRL, 8'h02, "R7 start while disabled");
    expectErr(DATA, 8'hA5, "R7 data outside session");

    // R2 + R11: timed START
    tm = 8'b01_010_0_01; L = qlen(tm);
    regWr(TIM, tm);
    s0 = startCnt;
    regWr(CTRL, 8'h03);
    repeat (4 * L - 1) @(negedge clk);
    peek(STAT, v); chk(v[7] && !v[3], "R2 start busy", v, 8'h80);
    @(negedge clk);
    peek(STAT, v); chk(!v[7] && v[3], "R2 start done", v, 8'h08);
    chk(startCnt == s0 + 1, "R2 start condition", startCnt - s0, 1);
    expectErr(CTRL, 8'h0B, "R7 request before no-action");
    regWr(CTRL, 8'h01);
    regWr(STAT, 8'h0F);
    expectErr(CTRL, 8'h03, "R7 start inside session");

    // bytes: first timed, the rest with random timing words
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      logic a;
      if (i > 0) begin tm = 8'($urandom); regWr(TIM, tm); end
      b = 8'($urandom); a = 1'($urandom);
      if (i == 2) b = 8'h00;
      if (i == 3) b = 8'hFF;
      sendByte(b, a, i == 0, qlen(tm));
      if (i == 1) begin
        regWr(STAT, 8'h02);
        regRd(STAT, v);
        chk(!v[1] && v[3], "R8 partial clear", v & 8'h0A, 8'h08);
      end
      regWr(STAT, 8'h0F);
      regRd(STAT, v);
      chk(v == 8'h00, "R8 full clear", v, 0);
    end

    // R9: interrupt follows enabled flags
    regWr(IEN, 8'h02);
    sendByte(8'h3C, 1'b1, 1'b0, 0);
    @(negedge clk); chk(irq, "R9 irq on tx empty", irq, 1);
    regWr(STAT, 8'h08);
    @(negedge clk); chk(irq, "R9 irq held by other flag", irq, 1);
    regWr(STAT, 8'h02);
    @(negedge clk); chk(!irq, "R9 irq cleared", irq, 0);
    regWr(IEN, 8'h00);
    regWr(STAT, 8'h0F);

    // R5: repeated START
    s0 = startCnt;
    regWr(CTRL, 8'h0B); waitDone();
    chk(startCnt == s0 + 1, "R5 repeated start", startCnt - s0, 1);
    regWr(CTRL, 8'h01); regWr(STAT, 8'h0F);
    sendByte(8'hA1, 1'b1, 1'b0, 0);
    regWr(STAT, 8'h0F);

    // R6: STOP ends the session
    s0 = stopCnt;
    regWr(CTRL, 8'h05); waitDone();
    chk(stopCnt == s0 + 1, "R6 stop condition", stopCnt - s0, 1);
    chk(!sclOe && !sdaOe, "R6 bus released", {sclOe, sdaOe}, 0);
    regWr(CTRL, 8'h01); regWr(STAT, 8'h0F);
    expectErr(DATA, 8'h55, "R6 data after stop");

    // R10: pads disabled
    regWr(PAD, 8'h04);
    padWatch = 1'b1;
    regWr(CTRL, 8'h03); waitDone();
    regRd(STAT, v);
    chk(padViol == 0 && v[3], "R10 pads released", padViol, 0);
    regWr(CTRL, 8'h01); regWr(STAT, 8'h0F);
    regWr(CTRL, 8'h05); waitDone();
    padWatch = 1'b0;
    chk(padViol == 0, "R10 pads released on stop", padViol, 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 180000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule